// File: doc/BRIEF.md
# Rotate-Merge Shift Unit with MQ Register

This block executes one shift-right-extended operation per clock. It takes a 32-bit source word and rotates it right by a shift amount taken from the low five bits of a control word. It builds a mask from the same shift amount and blends the rotated word with the value already held in an internal auxiliary (MQ) register. The result of that blend is the destination value. The rotated word itself becomes the new MQ contents. Both results are registered on the same clock edge, and the merge always reads the MQ value from before that edge.

When the record input is set, the block also produces a 4-bit condition field from the destination value. The field holds the signed comparison of the value with zero, plus a copy of the summary-overflow input. When the record input is clear, the condition field keeps its last value. Instruction decode and the register file sit outside this block. The block has no overflow-enable form and does not touch any exception state.

Top module: `rotmerge_unit`

## Requirements
- R1: While reset (rst_n low) is applied, dest_o, mq_o and cr_o are all zero, and mq_we_o and cr_we_o are low.
- R2: The shift amount N is rb_i[4:0]. One cycle after op_valid_i is high at a clock edge, mq_o holds rs_i rotated right by N, which is the same as rotated left by 32-N. mq_we_o is high in that cycle.
- R3: The mask has N zero bits at the most-significant end and 32-N one bits below them. dest_o = (rotated AND mask) OR (previous MQ AND NOT mask). For example, rs_i=0x9000300F, N=4 and MQ=0xEFFFFFFF give dest_o=0xE9000300 and mq_o=0xF9000300.
- R4: In back-to-back operations, each merge uses the MQ value written by the operation just before it.
- R5: When N=0 the mask is all ones, so dest_o equals rs_i and the previous MQ has no effect.
- R6: Bits rb_i[31:5] have no effect on any output.
- R7: When rec_i=1, cr_o is set one cycle after the operation as follows: bit 3 is high when dest_o is negative, bit 2 is high when dest_o is positive, bit 1 is high when dest_o is zero, and bit 0 copies so_i. cr_we_o is high in that cycle. A negative result with so_i=0 gives 0x8.
- R8: When rec_i=0 in an operation, cr_o keeps its previous value and cr_we_o is low in the following cycle.
- R9: In a cycle after op_valid_i was low, dest_o and mq_o are unchanged, and mq_we_o and cr_we_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid_i | input | 1 | Execute one operation at this clock edge |
| rs_i | input | 32 | Source word to rotate |
| rb_i | input | 32 | Control word; bits 4:0 give the shift amount |
| rec_i | input | 1 | Record enable: update the condition field |
| so_i | input | 1 | Current summary-overflow flag |
| dest_o | output | 32 | Merged destination result |
| mq_o | output | 32 | MQ register contents |
| mq_we_o | output | 1 | Destination and MQ were written in this cycle |
| cr_o | output | 4 | Condition field {LT, GT, EQ, SO} |
| cr_we_o | output | 1 | Condition field was written in this cycle |

## Verification
The hardest case to reach from the ports is a merge that must read the MQ value from before the update. This only shows up when operations follow each other with no idle cycle and the masked-out bits differ between the old and new MQ. The stimulus first loads a known MQ through an N=0 operation. It then issues a chain of operations in consecutive cycles with varied shift amounts, so that each destination depends on the rotated word of its predecessor. It also issues the same low shift bits with noisy upper bits in the control word.

// File: rtl/rotmerge_pkg.sv
package rotmerge_pkg;
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_t;

  localparam int COND_W = $bits(cond_t);
endpackage

// File: rtl/rm_rotator.sv
module rm_rotator #(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] data_i,
  input  logic [SHW-1:0]  amt_i,
  output logic [XLEN-1:0] data_o
);
  logic [XLEN-1:0] stage [0:SHW];

  assign stage[0] = data_i;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int DIST = 1 << s;
    assign stage[s+1] = amt_i[s] ? {stage[s][DIST-1:0], stage[s][XLEN-1:DIST]}
                                 : stage[s];
  end

  assign data_o = stage[SHW];
endmodule

// File: rtl/rm_masker.sv
module rm_masker #(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [SHW-1:0]  amt_i,
  input  logic [XLEN-1:0] rot_i,
  input  logic [XLEN-1:0] old_mq_i,
  output logic [XLEN-1:0] mask_o,
  output logic [XLEN-1:0] merged_o
);
  // Bit i (LSB index) is kept from the rotated word when i < XLEN - N.
  for (genvar i = 0; i < XLEN; i++) begin : g_mask
    assign mask_o[i] = ({1'b0, amt_i} < (SHW+1)'(XLEN - i));
  end

  assign merged_o = (rot_i & mask_o) | (old_mq_i & ~mask_o);
endmodule

// File: rtl/rm_condgen.sv
module rm_condgen
  import rotmerge_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] value_i,
  input  logic            so_i,
  output cond_t           cond_o
);
  logic is_zero;
  logic is_neg;

  assign is_zero = (value_i == '0);
  assign is_neg  = value_i[XLEN-1];

  always_comb begin
    cond_o.lt = is_neg;
    cond_o.gt = !is_neg && !is_zero;
    cond_o.eq = is_zero;
    cond_o.so = so_i;
  end
endmodule

// File: rtl/rotmerge_unit.sv
module rotmerge_unit
  import rotmerge_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid_i,
  input  logic [XLEN-1:0]   rs_i,
  input  logic [XLEN-1:0]   rb_i,
  input  logic              rec_i,
  input  logic              so_i,
  output logic [XLEN-1:0]   dest_o,
  output logic [XLEN-1:0]   mq_o,
  output logic              mq_we_o,
  output logic [COND_W-1:0] cr_o,
  output logic              cr_we_o
);
  logic [SHW-1:0]  shamt_w;
  logic [XLEN-1:0] rot_w;
  logic [XLEN-1:0] mask_w;
  logic [XLEN-1:0] merged_w;
  cond_t           cond_w;
  logic            unused_rb_hi;

  logic [XLEN-1:0]   mq_q;
  logic [XLEN-1:0]   dest_q;
  logic [COND_W-1:0] cr_q;
  logic              mq_we_q;
  logic              cr_we_q;

  assign shamt_w      = rb_i[SHW-1:0];
  assign unused_rb_hi = ^rb_i[XLEN-1:SHW];

  rm_rotator #(.XLEN(XLEN)) u_rot (
    .data_i (rs_i),
    .amt_i  (shamt_w),
    .data_o (rot_w)
  );

  rm_masker #(.XLEN(XLEN)) u_mask (
    .amt_i    (shamt_w),
    .rot_i    (rot_w),
    .old_mq_i (mq_q),
    .mask_o   (mask_w),
    .merged_o (merged_w)
  );

  rm_condgen #(.XLEN(XLEN)) u_cond (
    .value_i (merged_w),
    .so_i    (so_i),
    .cond_o  (cond_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mq_q    <= '0;
      dest_q  <= '0;
      cr_q    <= '0;
      mq_we_q <= 1'b0;
      cr_we_q <= 1'b0;
    end else begin
      mq_we_q <= op_valid_i;
      cr_we_q <= op_valid_i && rec_i;
      if (op_valid_i) begin
        mq_q   <= rot_w;
        dest_q <= merged_w;
        if (rec_i) cr_q <= cond_w;
      end
    end
  end

  assign dest_o  = dest_q;
  assign mq_o    = mq_q;
  assign mq_we_o = mq_we_q;
  assign cr_o    = cr_q;
  assign cr_we_o = cr_we_q;
endmodule

// File: rtl/rotmerge_unit_chk.sv
module rotmerge_unit_chk #(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid_i,
  input logic [XLEN-1:0] rs_i,
  input logic [XLEN-1:0] rb_i,
  input logic            rec_i,
  input logic            so_i,
  input logic [XLEN-1:0] dest_o,
  input logic [XLEN-1:0] mq_o,
  input logic            mq_we_o,
  input logic [3:0]      cr_o,
  input logic            cr_we_o,
  input logic [XLEN-1:0] mask_w
);
  logic [SHW-1:0] n_w;
  logic           unused_rb_hi;
  assign n_w          = rb_i[SHW-1:0];
  assign unused_rb_hi = ^rb_i[XLEN-1:SHW];

  p_mask_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mask_w) == XLEN - int'(n_w));

  p_mask_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (n_w != '0) |-> !mask_w[XLEN-1]);

  p_merge_old_mq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_i |=> (((dest_o ^ $past(mq_o)) & ~$past(mask_w)) == '0)
                && (((dest_o ^ mq_o) & $past(mask_w)) == '0) && mq_we_o);

  p_n0_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && n_w == '0) |=> (dest_o == $past(rs_i)) && (mq_o == $past(rs_i)));

  p_cr_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && rec_i) |=> cr_we_o && (cr_o[0] == $past(so_i))
      && (cr_o[1] == (dest_o == '0)) && (cr_o[3] == dest_o[XLEN-1])
      && ($countones(cr_o[3:1]) == 1));

  p_cr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid_i && rec_i) |=> !cr_we_o && $stable(cr_o));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid_i |=> !mq_we_o && $stable(mq_o) && $stable(dest_o));
endmodule

bind rotmerge_unit rotmerge_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid_i (op_valid_i),
  .rs_i       (rs_i),
  .rb_i       (rb_i),
  .rec_i      (rec_i),
  .so_i       (so_i),
  .dest_o     (dest_o),
  .mq_o       (mq_o),
  .mq_we_o    (mq_we_o),
  .cr_o       (cr_o),
  .cr_we_o    (cr_we_o),
  .mask_w     (mask_w)
);

// File: tb/rotmerge_unit_bench.sv
module rotmerge_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  // Stimulus table: {rs, rb, rec, so}
  localparam logic [65:0] VEC [NVEC] = '{
    {32'h1234_5678, 32'h0000_0008, 1'b1, 1'b0},
    {32'h8000_0001, 32'h0000_001F, 1'b1, 1'b1},
    {32'h0000_0000, 32'h0000_0010, 1'b1, 1'b0},
    {32'hDEAD_BEEF, 32'h0000_0001, 1'b0, 1'b0},
    {32'hFFFF_0000, 32'h0000_000C, 1'b1, 1'b0},
    {32'h0F0F_0F0F, 32'h0000_0003, 1'b1, 1'b1},
    {32'h7FFF_FFFF, 32'h0000_0000, 1'b1, 1'b0},
    {32'hA5A5_5A5A, 32'h0000_0017, 1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid_i;
  logic [31:0] rs_i, rb_i;
  logic        rec_i, so_i;
  logic [31:0] dest_o, mq_o;
  logic        mq_we_o;
  logic [3:0]  cr_o;
  logic        cr_we_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [31:0] m_mq, m_dest;
  logic [3:0]  m_cr;

  always #(CLK_PERIOD/2) clk = ~clk;

  rotmerge_unit u_rotmerge_unit (
    .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .rs_i(rs_i), .rb_i(rb_i),
    .rec_i(rec_i), .so_i(so_i), .dest_o(dest_o), .mq_o(mq_o), .mq_we_o(mq_we_o),
    .cr_o(cr_o), .cr_we_o(cr_we_o)
  );

  function automatic logic [31:0] m_rotr(logic [31:0] v, int n);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[(i + n) % 32];
    return r;
  endfunction

  function automatic logic [31:0] m_maskof(int n);
    logic [31:0] m;
    for (int k = 0; k < 32; k++) m[31-k] = (k >= n);
    return m;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(logic [31:0] rs, logic [31:0] rb, logic rec, logic so, string tag);
    logic [31:0] rot, msk, dst;
    int n;
    @(negedge clk);
    op_valid_i = 1'b1; rs_i = rs; rb_i = rb; rec_i = rec; so_i = so;
    n   = int'(rb[4:0]);
    rot = m_rotr(rs, n);
    msk = m_maskof(n);
    dst = (rot & msk) | (m_mq & ~msk);
    @(posedge clk); #1;
    m_mq = rot; m_dest = dst;
    if (rec) m_cr = {dst[31], !dst[31] && dst != 0, dst == 0, so};
    chk({tag, " R2 mq"}, mq_o, m_mq);
    chk({tag, " R3 dest"}, dest_o, m_dest);
    chk({tag, " R2 mq_we"}, {31'd0, mq_we_o}, 32'd1);
    chk({tag, " R7/R8 cr"}, {28'd0, cr_o}, {28'd0, m_cr});
    chk({tag, " R7/R8 cr_we"}, {31'd0, cr_we_o}, {31'd0, rec});
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    op_valid_i = 1'b0; rs_i = 32'hFFFF_FFFF; rb_i = 32'h0000_0007; rec_i = 1'b1; so_i = 1'b1;
    @(posedge clk); #1;
    chk({tag, " R9 mq"}, mq_o, m_mq);
    chk({tag, " R9 dest"}, dest_o, m_dest);
    chk({tag, " R9 we"}, {30'd0, mq_we_o, cr_we_o}, 32'd0);
    chk({tag, " R9 cr"}, {28'd0, cr_o}, {28'd0, m_cr});
  endtask

  task automatic check_reset(string tag);
    chk({tag, " R1 dest"}, dest_o, 32'd0);
    chk({tag, " R1 mq"}, mq_o, 32'd0);
    chk({tag, " R1 cr/we"}, {26'd0, cr_o, mq_we_o, cr_we_o}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_valid_i = 1'b0; rs_i = '0; rb_i = '0; rec_i = 1'b0; so_i = 1'b0;
    m_mq = '0; m_dest = '0; m_cr = '0;
    repeat (3) @(posedge clk);
    #1 check_reset("initial");
    @(negedge clk); rst_n = 1'b1;

    // R5: N=0 loads MQ with an unrotated word; dest equals rs
    run_op(32'hEFFF_FFFF, 32'h0000_0000, 1'b0, 1'b0, "load");
    chk("R5 dest=rs", dest_o, 32'hEFFF_FFFF);

    // R3: worked example with fixed expected values, R7 negative with SO clear
    run_op(32'h9000_300F, 32'h0000_0004, 1'b1, 1'b0, "example");
    chk("R3 example dest", dest_o, 32'hE900_0300);
    chk("R3 example mq", mq_o, 32'hF900_0300);
    chk("R7 example cr", {28'd0, cr_o}, 32'h8);

    // R4: consecutive operations, each merge reads the previous MQ
    for (int v = 0; v < NVEC; v++)
      run_op(VEC[v][65:34], VEC[v][33:2], VEC[v][1], VEC[v][0], "R4 table");

    // R6: upper control bits ignored
    run_op(32'hC003_1234, 32'hFFFF_FFE5, 1'b1, 1'b0, "R6 noisy rb");
    run_op(32'hC003_1234, 32'h0000_0005, 1'b1, 1'b0, "R6 clean rb");
    chk("R6 same mq", mq_o, m_rotr(32'hC003_1234, 5));

    // R7: zero result gives EQ with SO copied; R5 N=0 with old MQ ignored
    run_op(32'h0000_0000, 32'h0000_0000, 1'b1, 1'b1, "R7 zero");
    chk("R7 zero cr", {28'd0, cr_o}, 32'h3);

    // R8: record clear keeps the condition field
    run_op(32'h8000_0000, 32'h0000_0002, 1'b0, 1'b0, "R8 no record");
    chk("R8 cr held", {28'd0, cr_o}, 32'h3);

    // R9: idle cycles hold everything
    idle("idle1");
    idle("idle2");

    // R1: reset in mid-run clears state
    @(negedge clk); rst_n = 1'b0; op_valid_i = 1'b1;
    @(posedge clk); #1 check_reset("midrun");
    @(negedge clk); rst_n = 1'b1; op_valid_i = 1'b0;
    m_mq = '0; m_dest = '0; m_cr = '0;
    run_op(32'h0000_0010, 32'h0000_0004, 1'b1, 1'b0, "R1 after reset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule